// File: doc/BRIEF.md
# Bit-banged I2C target decoder

This block recovers I2C transactions from two wire levels that a processor toggles through general-purpose output bits. Both levels are sampled once per system clock, and each sample is compared with the previous one to find edges. Bits are taken on the falling edge of the clock line. The first byte after a START is the address byte, and its lowest bit selects the direction. In a write, every later byte is handed out on a write-data strobe. In a read, the block takes a byte from a parallel source and drives it, most significant bit first, on a data-return output. The processor reads that output back as its sampled data line.

Toward the byte side there are four kinds of single-cycle pulse: transfer start (with the address and direction), write data, read-byte taken, and transfer end. The read source has no request-and-wait handshake. It keeps the next byte to send on `rd_data_i` at all times, and it moves to the following byte when it sees `rd_take_o`.

Top module: `bitbang_i2c_dec`

## Requirements
- R1: After reset the block is idle, all strobes are low and `sda_ret_o` is 1. Reset treats both previous line levels as 1.
- R2: When idle, the block reacts only to a START, which is `sda_i` going from 1 to 0 while `scl_i` is 1. Clock pulses and data edges outside a START give no strobe and leave `sda_ret_o` at 1.
- R3: Once a START is seen, the first falling edge of `scl_i` with `sda_i` low arms the bit shifter. Each of the next eight falling edges shifts in one `sda_i` level, with the first bit becoming the byte's bit 7.
- R4: At the ninth falling edge of the first byte, `xfer_start_o` pulses for one cycle. `addr_o` then shows that byte with bit 0 forced to 0, and `rnw_o` shows its bit 0 (1 means read).
- R5: In a write transfer, the ninth falling edge of every later byte pulses `wr_valid_o` with the byte on `wr_data_o`. `wr_valid_o` and `rd_take_o` never pulse in the same cycle.
- R6: From the eighth falling edge of a received byte until the ninth, `sda_ret_o` is 0 (acknowledge). Outside the read-bit phase it is 1.
- R7: In a read transfer, the ninth falling edge of the address byte loads `rd_data_i` and pulses `rd_take_o`. `sda_ret_o` then shows that byte from bit 7 down, and moves to the next bit on each falling edge.
- R8: After eight read bits `sda_ret_o` returns to 1 for the acknowledge clock. The falling edge that ends that clock loads the next `rd_data_i`, pulses `rd_take_o` and starts a new read byte.
- R9: In any non-idle state, `sda_i` rising while `scl_i` is 1 is a STOP and returns the block to idle. `xfer_end_o` pulses only if an address byte had been latched, and the next byte after a later START is again treated as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both lines are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Sampled data line level |
| scl_i | input | 1 | Sampled clock line level |
| rd_data_i | input | BYTE_W | Next byte to return in a read, held by the source |
| sda_ret_o | output | 1 | Level the target drives back on the data line |
| xfer_start_o | output | 1 | One-cycle pulse: address byte accepted |
| addr_o | output | BYTE_W | Latched address byte with bit 0 cleared |
| rnw_o | output | 1 | Direction bit of the latched address (1 = read) |
| wr_valid_o | output | 1 | One-cycle pulse: write byte on `wr_data_o` |
| wr_data_o | output | BYTE_W | Last write byte received |
| rd_take_o | output | 1 | One-cycle pulse: `rd_data_i` was loaded |
| xfer_end_o | output | 1 | One-cycle pulse: STOP closed an open transfer |

## Verification
Most state errors in this decoder show up within one bit time as a wrong level on `sda_ret_o`. A bit counter that is off by one moves the low acknowledge slot or shifts the read byte by one position. A shifter that loses a bit puts a wrong value on `addr_o` or `wr_data_o` at the very next byte strobe. A stale address-valid flag appears at the next transaction: its first byte comes out as a write strobe instead of a start, or a STOP with no open transfer pulses `xfer_end_o`. The bench compares every strobe against a queue of expected events in order and checks `sda_ret_o` at each bit of each acknowledge and read phase.

// File: rtl/bbi2c_pkg.sv
package bbi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SHIFT_IN,
    ST_ACK_WAIT,
    ST_SHIFT_OUT,
    ST_ACK_SEND
  } dec_state_e;
endpackage

// File: rtl/bbi2c_edge.sv
module bbi2c_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_rise_o,
  output logic sda_fall_o,
  output logic scl_fall_o
);
  logic sda_q, scl_q;

  // previous levels reset high: idle bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  assign sda_rise_o = sda_i & ~sda_q;
  assign sda_fall_o = ~sda_i & sda_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/bbi2c_core.sv
module bbi2c_core
  import bbi2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              scl_fall_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_ret_o,
  output logic              xfer_start_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic              rnw_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_take_o,
  output logic              xfer_end_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  dec_state_e        state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              addr_vld_q;
  logic              stop_ev, start_ev, go_rd;

  assign stop_ev  = sda_rise_i & scl_i;
  assign start_ev = sda_fall_i & scl_i;
  // direction: byte just received if it is the address, else latched one
  assign go_rd    = addr_vld_q ? addr_q[0] : shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      shreg_q      <= '0;
      addr_q       <= '0;
      cnt_q        <= '0;
      addr_vld_q   <= 1'b0;
      xfer_start_o <= 1'b0;
      wr_valid_o   <= 1'b0;
      wr_data_o    <= '0;
      rd_take_o    <= 1'b0;
      xfer_end_o   <= 1'b0;
    end else begin
      xfer_start_o <= 1'b0;
      wr_valid_o   <= 1'b0;
      rd_take_o    <= 1'b0;
      xfer_end_o   <= 1'b0;
      if (state_q != ST_IDLE && stop_ev) begin
        state_q    <= ST_IDLE;
        xfer_end_o <= addr_vld_q;
        addr_vld_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_ev) state_q <= ST_ARMED;
          ST_ARMED: if (scl_fall_i && !sda_i) begin
            state_q <= ST_SHIFT_IN;
            cnt_q   <= '0;
          end
          ST_SHIFT_IN: if (scl_fall_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) state_q <= ST_ACK_WAIT;
          end
          ST_ACK_WAIT: if (scl_fall_i) begin
            if (!addr_vld_q) begin
              addr_q       <= shreg_q;
              addr_vld_q   <= 1'b1;
              xfer_start_o <= 1'b1;
            end else begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= shreg_q;
            end
            cnt_q <= '0;
            if (go_rd) begin
              state_q   <= ST_SHIFT_OUT;
              shreg_q   <= rd_data_i;
              rd_take_o <= 1'b1;
            end else begin
              state_q <= ST_SHIFT_IN;
            end
          end
          ST_SHIFT_OUT: if (scl_fall_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) state_q <= ST_ACK_SEND;
          end
          ST_ACK_SEND: if (scl_fall_i) begin
            state_q   <= ST_SHIFT_OUT;
            shreg_q   <= rd_data_i;
            cnt_q     <= '0;
            rd_take_o <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign addr_o = {addr_q[BYTE_W-1:1], 1'b0};
  assign rnw_o  = addr_q[0];

  always_comb begin
    unique case (state_q)
      ST_SHIFT_OUT: sda_ret_o = shreg_q[BYTE_W-1];
      ST_ACK_WAIT:  sda_ret_o = 1'b0;
      default:      sda_ret_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bitbang_i2c_dec.sv
module bitbang_i2c_dec #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_ret_o,
  output logic              xfer_start_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic              rnw_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_take_o,
  output logic              xfer_end_o
);
  logic sda_rise, sda_fall, scl_fall;

  bbi2c_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .sda_rise_o (sda_rise),
    .sda_fall_o (sda_fall),
    .scl_fall_o (scl_fall)
  );

  bbi2c_core #(.BYTE_W(BYTE_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_i),
    .scl_i        (scl_i),
    .sda_rise_i   (sda_rise),
    .sda_fall_i   (sda_fall),
    .scl_fall_i   (scl_fall),
    .rd_data_i    (rd_data_i),
    .sda_ret_o    (sda_ret_o),
    .xfer_start_o (xfer_start_o),
    .addr_o       (addr_o),
    .rnw_o        (rnw_o),
    .wr_valid_o   (wr_valid_o),
    .wr_data_o    (wr_data_o),
    .rd_take_o    (rd_take_o),
    .xfer_end_o   (xfer_end_o)
  );
endmodule

// File: rtl/bbi2c_chk.sv
module bbi2c_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_i,
  input logic              scl_i,
  input logic              sda_ret_o,
  input logic              xfer_start_o,
  input logic              rnw_o,
  input logic              wr_valid_o,
  input logic              rd_take_o,
  input logic              xfer_end_o
);
  // R4: start strobe follows a sampled falling clock edge
  a_r4_start_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> ($past(scl_i, 2) && !$past(scl_i)));

  // R5: write strobe follows a sampled falling clock edge
  a_r5_write_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($past(scl_i, 2) && !$past(scl_i)));

  a_r5_wr_take_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_valid_o, rd_take_o}) <= 1);

  // R7: read take follows a falling clock edge; with a start it is a read address
  a_r7_take_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_take_o |-> ($past(scl_i, 2) && !$past(scl_i)));

  a_r7_take_is_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_take_o && xfer_start_o) |-> rnw_o);

  // R9: end strobe only after a data rise with clock high, and leaves bus released
  a_r9_end_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2)));

  a_r9_end_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> sda_ret_o);
endmodule

bind bitbang_i2c_dec bbi2c_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sda_i        (sda_i),
  .scl_i        (scl_i),
  .sda_ret_o    (sda_ret_o),
  .xfer_start_o (xfer_start_o),
  .rnw_o        (rnw_o),
  .wr_valid_o   (wr_valid_o),
  .rd_take_o    (rd_take_o),
  .xfer_end_o   (xfer_end_o)
);

// File: tb/sim_bitbang_i2c_dec.sv
`timescale 1ns/1ps
module sim_bitbang_i2c_dec;
  localparam int W = 8;

  typedef struct {
    int    kind;   // 0 start, 1 write, 2 take, 3 end
    int    val;
    string tag;
  } ev_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sda = 1'b1, scl = 1'b1;
  logic [W-1:0] rdata = '0;
  logic         sda_ret, st, rnw, wv, take, en;
  logic [W-1:0] addr, wdata;

  int  errs = 0, checks = 0;
  bit  done = 1'b0;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;

  bitbang_i2c_dec #(.BYTE_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl), .rd_data_i(rdata),
    .sda_ret_o(sda_ret), .xfer_start_o(st), .addr_o(addr), .rnw_o(rnw),
    .wr_valid_o(wv), .wr_data_o(wdata), .rd_take_o(take), .xfer_end_o(en)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, int val, string tag);
    ev_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(int kind, int val);
    ev_t e;
    if (exp_q.size() == 0) begin
      checks++; errs++;
      $display("FAIL R2 unexpected strobe kind actual=%0d expected=none", kind);
    end else begin
      e = exp_q.pop_front();
      check({e.tag, " kind"}, kind, e.kind);
      check({e.tag, " value"}, val, e.val);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (st)   pop_cmp(0, int'(addr));
      if (wv)   pop_cmp(1, int'(wdata));
      if (take) pop_cmp(2, 0);
      if (en)   pop_cmp(3, 0);
    end
  end

  task automatic set(logic d, logic c);
    @(negedge clk);
    sda = d; scl = c;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_start();
    set(1, 0); set(1, 1); set(0, 1); set(0, 0);
  endtask

  task automatic do_stop();
    set(0, 0); set(0, 1); set(1, 1);
  endtask

  task automatic send_byte(logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) begin
      set(b[i], 0); set(b[i], 1); set(b[i], 0);
    end
  endtask

  task automatic ack_clock();
    set(1, 0); set(1, 1); set(1, 0);
  endtask

  task automatic read_byte(logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) begin
      check("R7 read bit", int'(sda_ret), int'(b[i]));
      set(1, 1); set(1, 0);
    end
    check("R8 ack-send level", int'(sda_ret), 1);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sda_ret", int'(sda_ret), 1);
    check("R1 strobes", int'({st, wv, take, en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 noise in idle: clocks, data edges, stop-like rise
    set(1, 0); set(1, 1); set(0, 1); // wait: fall with clock high is a START
    set(1, 1);                        // stop while armed, no address -> no end
    set(1, 0); set(0, 0); set(0, 1); set(1, 1); set(1, 0); set(1, 1);
    check("R2 idle sda_ret", int'(sda_ret), 1);

    // write transaction: addr 0x5A, data 0xC3, 0x80, 0x01
    do_start();
    send_byte(8'h5A);
    check("R6 ack low", int'(sda_ret), 0);
    push(0, 'h5A, "R4 write addr");
    ack_clock();
    check("R6 released", int'(sda_ret), 1);
    check("R4 rnw write", int'(rnw), 0);
    send_byte(8'hC3);
    check("R6 ack low data", int'(sda_ret), 0);
    push(1, 'hC3, "R3 R5 data");
    ack_clock();
    send_byte(8'h80);
    push(1, 'h80, "R3 msb first");
    ack_clock();
    send_byte(8'h01);
    push(1, 'h01, "R3 lsb last");
    ack_clock();
    push(3, 0, "R9 end write");
    do_stop();
    check("R9 idle after stop", int'(sda_ret), 1);

    // read transaction: addr 0x35 -> 0x34 read
    rdata = 8'hA5;
    do_start();
    send_byte(8'h35);
    check("R6 ack low read addr", int'(sda_ret), 0);
    push(0, 'h34, "R4 read addr bit0 cleared");
    push(2, 0, "R7 first take");
    ack_clock();
    check("R4 rnw read", int'(rnw), 1);
    rdata = 8'h3C;
    read_byte(8'hA5);
    push(2, 0, "R8 next take");
    ack_clock();
    read_byte(8'h3C);
    push(3, 0, "R9 end read");
    do_stop();
    check("R9 idle after read", int'(sda_ret), 1);

    // aborted: stop before address latched -> no end
    do_start();
    set(1, 0); set(1, 1); set(1, 0);
    set(0, 0); set(0, 1); set(0, 0);
    set(1, 0); set(1, 1); set(1, 0);
    do_stop();
    check("R9 no end without address", int'(exp_q.size()), 0);
    check("R9 aborted idle", int'(sda_ret), 1);

    // fresh transfer: first byte again an address
    do_start();
    send_byte(8'h20);
    push(0, 'h20, "R9 address after stop");
    ack_clock();
    push(3, 0, "R9 end short");
    do_stop();

    repeat (4) @(negedge clk);
    check("R5 queue drained", int'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule